// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Parser

This block turns one transmit frame descriptor into a series of read commands for a payload mover. A 128-byte descriptor comes in as 32 little-endian 32-bit words on a valid/ready stream. It holds a count of active buffer entries and up to twenty 6-byte entries. Each entry gives a 36-bit host address and a 12-bit byte length. The parser keeps the whole descriptor and checks the count and every active length. It then issues one command per active entry on a second valid/ready stream, and marks the first and the last command of the frame.

Descriptors live on a 256-slot ring. The host states its write position on `host_wr_idx`. The parser keeps the read position and advances it once per finished descriptor, including a rejected one. When the two positions are equal the ring is empty, and the parser stops taking descriptor words. On the command stream, `cmd_valid` stays high and every command field stays unchanged until `cmd_ready` is sampled high. On the descriptor stream, a word moves only on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low for the whole time the parser is checking or issuing commands.

For each descriptor, a one-cycle `desc_done` pulse reports the frame length and three error flags. The flags are: a bad count, a bad length, and a frame that was cut short because it would pass 8192 bytes.

Top module: `sg_tx_desc_parser`

## Requirements
- R1: Byte b of the descriptor is bits 8*(b%4)+7..8*(b%4) of word b/4, and words arrive in order 0..31. A word is taken only when `in_valid` and `in_ready` are both high. `in_ready` is low while commands are pending or being checked.
- R2: The active count is bits 4:0 of byte 3. Bits 7:5 of that byte, bytes 0..2 and bytes 124..127 have no effect on any output.
- R3: Entry k starts at byte 4+6k. Its first four bytes are address bits 31:0, little-endian. The next two bytes form a little-endian 16-bit word: bits 3:0 are address bits 35:32 and bits 15:4 are the length. Commands come out in entry order, one per active entry.
- R4: Once raised, `cmd_valid` stays high with `cmd_addr`, `cmd_len`, `cmd_first` and `cmd_last` unchanged until `cmd_ready` is high. `cmd_first` marks the first command of a descriptor and `cmd_last` marks its final one.
- R5: A count of 0 or above 20 gives `desc_done` with `err_count` set and `frame_len` 0, and no command is issued.
- R6: If any active entry has length 0 or above 4092, the result is `desc_done` with `err_len` set, no command, and `frame_len` 0. Entries at or beyond the count are ignored.
- R7: On `desc_done`, `frame_len` is the sum of the issued lengths. If adding the next entry would push the sum past 8192, the current command is marked last and `err_oversize` is set. A sum of exactly 8192 is allowed.
- R8: `rd_idx` increases by one, modulo 256, in the cycle `desc_done` is reported. This covers every descriptor, aborted ones included.
- R9: While `rd_idx` equals `host_wr_idx`, `in_ready` stays low and no descriptor word is taken.
- R10: After reset, `cmd_valid`, `desc_done` and `rd_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor word valid |
| in_ready | output | 1 | Parser accepts a descriptor word |
| in_data | input | 32 | Descriptor word, little-endian bytes |
| host_wr_idx | input | 8 | Host ring write position |
| rd_idx | output | 8 | Parser ring read position |
| cmd_valid | output | 1 | Read command valid |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_addr | output | 36 | Buffer host address |
| cmd_len | output | 12 | Buffer length in bytes |
| cmd_first | output | 1 | First command of the frame |
| cmd_last | output | 1 | Last command of the frame |
| desc_done | output | 1 | One-cycle end-of-descriptor pulse |
| err_count | output | 1 | Count out of range (with desc_done) |
| err_len | output | 1 | Illegal buffer length (with desc_done) |
| err_oversize | output | 1 | Frame cut at the 8192-byte limit (with desc_done) |
| frame_len | output | 14 | Total issued bytes (with desc_done) |

## Verification
Several internal faults show up directly at the ports:
- A word counter that slips out of step shifts every later byte. The error shows in the addresses and lengths of the very next descriptor's commands, or as a false count error at its `desc_done`.
- An entry index that skips or repeats gives a command whose address or length does not match the expected entry. This is seen at the handshake where it happens.
- A wrong running total shows in `frame_len`, or as a misplaced `cmd_last`, at the same descriptor's `desc_done`.
- A read position that drifts is compared against the count of finished descriptors at every `desc_done`. It also shows as words taken, or not taken, while the ring looks empty.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

  typedef enum logic [1:0] {
    SGP_LOAD  = 2'd0,
    SGP_CHECK = 2'd1,
    SGP_EMIT  = 2'd2
  } sgp_state_e;

  // byte offset of buffer entry k inside the descriptor
  function automatic int entry_offset(input int base, input int size, input int k);
    return base + size * k;
  endfunction

endpackage

// File: rtl/sgp_desc_buf.sv
module sgp_desc_buf #(
  parameter int WORD_W     = 32,
  parameter int DESC_WORDS = 32,
  localparam int CNT_W     = $clog2(DESC_WORDS),
  localparam int FLAT_W    = WORD_W * DESC_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              full_pulse,
  output logic [FLAT_W-1:0] desc_flat
);

  logic [CNT_W-1:0] wcnt;
  logic             take;
  logic             at_end;

  assign in_ready   = load_en;
  assign take       = in_valid && in_ready;
  assign at_end     = (wcnt == CNT_W'(DESC_WORDS - 1));
  assign full_pulse = take && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (take) begin
      wcnt <= at_end ? '0 : wcnt + 1'b1;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (take && (wcnt == CNT_W'(g))) begin
        word_q <= in_data;
      end
    end
    assign desc_flat[g*WORD_W +: WORD_W] = word_q;
  end

  // counter only moves on an accepted word
  AST_WCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(wcnt)); // R1

endmodule

// File: rtl/sgp_entry_decode.sv
module sgp_entry_decode #(
  parameter int WORD_W      = 32,
  parameter int DESC_WORDS  = 32,
  parameter int MAX_ENT     = 20,
  parameter int ADDR_W      = 36,
  parameter int LEN_W       = 12,
  parameter int MAX_BUF_LEN = 4092,
  parameter int CNT_BYTE    = 3,
  parameter int CNT_FW      = 5,
  parameter int ENT_BASE    = 4,
  localparam int FLAT_W     = WORD_W * DESC_WORDS,
  localparam int LO_W       = 32,
  localparam int HI_W       = ADDR_W - LO_W,
  localparam int HW_W       = HI_W + LEN_W,
  localparam int ENT_BYTES  = (LO_W + HW_W) / 8
) (
  input  logic [FLAT_W-1:0]              desc_flat,
  output logic [MAX_ENT-1:0][ADDR_W-1:0] entry_addr,
  output logic [MAX_ENT-1:0][LEN_W-1:0]  entry_len,
  output logic [CNT_FW-1:0]              count,
  output logic                           count_bad,
  output logic                           len_bad
);

  logic [MAX_ENT-1:0] bad_vec;
  logic               unused_bits;

  assign count     = desc_flat[8*CNT_BYTE +: CNT_FW];
  assign count_bad = (count == '0) || (int'(count) > MAX_ENT);

  for (genvar g = 0; g < MAX_ENT; g++) begin : g_ent
    localparam int OFF = 8 * sgp_pkg::entry_offset(ENT_BASE, ENT_BYTES, g);
    logic [LO_W-1:0] lo;
    logic [HW_W-1:0] hw;
    logic            active;

    assign lo            = desc_flat[OFF +: LO_W];
    assign hw            = desc_flat[OFF + LO_W +: HW_W];
    assign entry_addr[g] = {hw[HI_W-1:0], lo};
    assign entry_len[g]  = hw[HW_W-1:HI_W];
    assign active        = (g < int'(count));
    assign bad_vec[g]    = active &&
                           ((entry_len[g] == '0) || (entry_len[g] > LEN_W'(MAX_BUF_LEN)));
  end

  assign len_bad     = |bad_vec;
  assign unused_bits = ^desc_flat;

endmodule

// File: rtl/sgp_ring_idx.sv
module sgp_ring_idx #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             empty
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx <= '0;
    end else if (advance) begin
      rd_idx <= rd_idx + 1'b1;
    end
  end

  assign empty = (rd_idx == wr_idx);

endmodule

// File: rtl/sgp_cmd_seq.sv
module sgp_cmd_seq #(
  parameter int MAX_ENT     = 20,
  parameter int ADDR_W      = 36,
  parameter int LEN_W       = 12,
  parameter int CNT_FW      = 5,
  parameter int MAX_BUF_LEN = 4092,
  parameter int MAX_FRAME   = 8192,
  localparam int EIDX_W     = $clog2(MAX_ENT + 1),
  localparam int TOT_W      = $clog2(MAX_FRAME + 2 * (1 << LEN_W))
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           full_pulse,
  input  logic [CNT_FW-1:0]              count,
  input  logic                           count_bad,
  input  logic                           len_bad,
  input  logic [MAX_ENT-1:0][ADDR_W-1:0] entry_addr,
  input  logic [MAX_ENT-1:0][LEN_W-1:0]  entry_len,
  input  logic                           cmd_ready,
  output logic                           load_phase,
  output logic                           advance,
  output logic                           cmd_valid,
  output logic [ADDR_W-1:0]              cmd_addr,
  output logic [LEN_W-1:0]               cmd_len,
  output logic                           cmd_first,
  output logic                           cmd_last,
  output logic                           desc_done,
  output logic                           err_count,
  output logic                           err_len,
  output logic                           err_oversize,
  output logic [TOT_W-1:0]               frame_len
);
  import sgp_pkg::*;

  sgp_state_e        state;
  logic [EIDX_W-1:0] eidx;
  logic [EIDX_W-1:0] eidx_nx;
  logic [TOT_W-1:0]  total;
  logic [TOT_W-1:0]  sum;
  logic [LEN_W-1:0]  nxt_len;
  logic              is_final;
  logic              cut;
  logic              reject;

  assign reject    = count_bad || len_bad;
  assign eidx_nx   = eidx + 1'b1;
  assign cmd_len   = entry_len[eidx];
  assign cmd_addr  = entry_addr[eidx];
  assign sum       = total + TOT_W'(cmd_len);
  assign nxt_len   = (int'(eidx) + 1 < MAX_ENT) ? entry_len[eidx_nx] : '0;
  assign is_final  = (int'(eidx) + 1 == int'(count));
  assign cut       = !is_final && ((sum + TOT_W'(nxt_len)) > TOT_W'(MAX_FRAME));
  assign cmd_last  = is_final || cut;
  assign cmd_first = (eidx == '0);
  assign cmd_valid = (state == SGP_EMIT);

  assign load_phase = (state == SGP_LOAD);
  assign advance    = ((state == SGP_CHECK) && reject) ||
                      (cmd_valid && cmd_ready && cmd_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SGP_LOAD;
      eidx         <= '0;
      total        <= '0;
      desc_done    <= 1'b0;
      err_count    <= 1'b0;
      err_len      <= 1'b0;
      err_oversize <= 1'b0;
      frame_len    <= '0;
    end else begin
      desc_done    <= 1'b0;
      err_count    <= 1'b0;
      err_len      <= 1'b0;
      err_oversize <= 1'b0;
      case (state)
        SGP_LOAD: begin
          if (full_pulse) state <= SGP_CHECK;
        end
        SGP_CHECK: begin
          if (reject) begin
            desc_done <= 1'b1;
            err_count <= count_bad;
            err_len   <= !count_bad;
            frame_len <= '0;
            state     <= SGP_LOAD;
          end else begin
            eidx  <= '0;
            total <= '0;
            state <= SGP_EMIT;
          end
        end
        SGP_EMIT: begin
          if (cmd_ready) begin
            total <= sum;
            if (cmd_last) begin
              desc_done    <= 1'b1;
              err_oversize <= cut;
              frame_len    <= sum;
              state        <= SGP_LOAD;
            end else begin
              eidx <= eidx_nx;
            end
          end
        end
        default: state <= SGP_LOAD;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
                                   && $stable(cmd_last) && $stable(cmd_first))); // R4
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_len != '0) && (cmd_len <= LEN_W'(MAX_BUF_LEN)))); // R6
  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> (frame_len <= TOT_W'(MAX_FRAME))); // R7
  AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> ($countones({err_count, err_len, err_oversize}) <= 1)); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count || err_len || err_oversize) |-> desc_done); // R5
  AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && (err_count || err_len)) |-> (frame_len == '0)); // R5

endmodule

// File: rtl/sg_tx_desc_parser.sv
module sg_tx_desc_parser #(
  parameter int WORD_W      = 32,
  parameter int DESC_WORDS  = 32,
  parameter int MAX_ENT     = 20,
  parameter int ADDR_W      = 36,
  parameter int LEN_W       = 12,
  parameter int CNT_FW      = 5,
  parameter int MAX_BUF_LEN = 4092,
  parameter int MAX_FRAME   = 8192,
  parameter int RING_IDX_W  = 8,
  localparam int TOT_W      = $clog2(MAX_FRAME + 2 * (1 << LEN_W))
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WORD_W-1:0]     in_data,
  input  logic [RING_IDX_W-1:0] host_wr_idx,
  output logic [RING_IDX_W-1:0] rd_idx,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic [LEN_W-1:0]      cmd_len,
  output logic                  cmd_first,
  output logic                  cmd_last,
  output logic                  desc_done,
  output logic                  err_count,
  output logic                  err_len,
  output logic                  err_oversize,
  output logic [TOT_W-1:0]      frame_len
);

  localparam int FLAT_W = WORD_W * DESC_WORDS;

  logic                           load_phase;
  logic                           ring_empty;
  logic                           advance;
  logic                           full_pulse;
  logic [FLAT_W-1:0]              desc_flat;
  logic [MAX_ENT-1:0][ADDR_W-1:0] entry_addr;
  logic [MAX_ENT-1:0][LEN_W-1:0]  entry_len;
  logic [CNT_FW-1:0]              count;
  logic                           count_bad;
  logic                           len_bad;

  sgp_desc_buf #(.WORD_W(WORD_W), .DESC_WORDS(DESC_WORDS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_phase && !ring_empty),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .full_pulse(full_pulse),
    .desc_flat (desc_flat)
  );

  sgp_entry_decode #(
    .WORD_W(WORD_W), .DESC_WORDS(DESC_WORDS), .MAX_ENT(MAX_ENT), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .MAX_BUF_LEN(MAX_BUF_LEN), .CNT_BYTE(3), .CNT_FW(CNT_FW), .ENT_BASE(4)
  ) u_dec (
    .desc_flat (desc_flat),
    .entry_addr(entry_addr),
    .entry_len (entry_len),
    .count     (count),
    .count_bad (count_bad),
    .len_bad   (len_bad)
  );

  sgp_ring_idx #(.IDX_W(RING_IDX_W)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(advance),
    .wr_idx (host_wr_idx),
    .rd_idx (rd_idx),
    .empty  (ring_empty)
  );

  sgp_cmd_seq #(
    .MAX_ENT(MAX_ENT), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_FW(CNT_FW),
    .MAX_BUF_LEN(MAX_BUF_LEN), .MAX_FRAME(MAX_FRAME)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_pulse  (full_pulse),
    .count       (count),
    .count_bad   (count_bad),
    .len_bad     (len_bad),
    .entry_addr  (entry_addr),
    .entry_len   (entry_len),
    .cmd_ready   (cmd_ready),
    .load_phase  (load_phase),
    .advance     (advance),
    .cmd_valid   (cmd_valid),
    .cmd_addr    (cmd_addr),
    .cmd_len     (cmd_len),
    .cmd_first   (cmd_first),
    .cmd_last    (cmd_last),
    .desc_done   (desc_done),
    .err_count   (err_count),
    .err_len     (err_len),
    .err_oversize(err_oversize),
    .frame_len   (frame_len)
  );

  AST_STALL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == host_wr_idx) |-> !in_ready); // R9
  AST_NO_CMD_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cmd_valid); // R1
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> (rd_idx == RING_IDX_W'($past(rd_idx) + 1'b1))); // R8

endmodule

// File: tb/test_sg_tx_desc_parser.sv
module test_sg_tx_desc_parser;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic [7:0]  host_wr_idx;
  logic [7:0]  rd_idx;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [35:0] cmd_addr;
  logic [11:0] cmd_len;
  logic        cmd_first;
  logic        cmd_last;
  logic        desc_done;
  logic        err_count;
  logic        err_len;
  logic        err_oversize;
  logic [13:0] frame_len;

  always #2 clk = ~clk;

  sg_tx_desc_parser i_sg_tx_desc_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .host_wr_idx(host_wr_idx), .rd_idx(rd_idx), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_first(cmd_first), .cmd_last(cmd_last),
    .desc_done(desc_done), .err_count(err_count), .err_len(err_len),
    .err_oversize(err_oversize), .frame_len(frame_len)
  );

  typedef struct packed {
    logic [35:0] addr;
    logic [11:0] len;
    logic        first;
    logic        last;
  } cmd_t;

  typedef struct packed {
    logic        ec;
    logic        el;
    logic        eo;
    logic [13:0] flen;
    logic [7:0]  ridx;
  } evt_t;

  cmd_t        exp_cmds[$];
  evt_t        exp_evts[$];
  logic [35:0] ent_addr[20];
  logic [11:0] ent_len[20];
  int          n_checks = 0;
  int          n_errs   = 0;
  int          sent     = 0;
  bit          finished = 1'b0;
  bit          mon_on   = 1'b0;
  logic [31:0] rng_in   = 32'h1234_5678;
  logic [31:0] rng_out  = 32'h0bad_cafe;

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  // queue expectations from the requirements, then stream the 32 words
  task automatic send_desc(input logic [7:0] cbyte);
    logic [7:0]  bytes[128];
    logic [15:0] hw;
    evt_t        e;
    int          cnt;
    int          total;
    int          s;
    bit          bad;
    bit          fin;
    bit          cut;
    bit          acc;
    cnt = int'(cbyte[4:0]);
    sent++;
    e = '0;
    e.ridx = 8'(sent);
    if (cnt == 0 || cnt > 20) begin
      e.ec = 1'b1;                                   // R5
    end else begin
      bad = 1'b0;
      for (int k = 0; k < cnt; k++)
        if (ent_len[k] == 12'd0 || ent_len[k] > 12'd4092) bad = 1'b1;
      if (bad) begin
        e.el = 1'b1;                                 // R6
      end else begin
        total = 0;
        for (int k = 0; k < cnt; k++) begin
          s   = total + int'(ent_len[k]);
          fin = (k == cnt - 1);
          cut = !fin && (s + int'(ent_len[k+1]) > 8192);   // R7
          exp_cmds.push_back('{ent_addr[k], ent_len[k], k == 0, fin || cut});
          total = s;
          if (fin || cut) begin
            e.eo = cut;
            break;
          end
        end
        e.flen = 14'(total);
      end
    end
    exp_evts.push_back(e);

    for (int b = 0; b < 128; b++) bytes[b] = (b < 3) ? 8'h5A : 8'hA5;
    bytes[3] = cbyte;
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < 4; i++) bytes[4 + 6*k + i] = ent_addr[k][8*i +: 8];
      hw = {ent_len[k], ent_addr[k][35:32]};
      bytes[4 + 6*k + 4] = hw[7:0];
      bytes[4 + 6*k + 5] = hw[15:8];
    end

    @(negedge clk);
    host_wr_idx = 8'(sent);
    for (int w = 0; w < 32; w++) begin
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        rng_in   = xs(rng_in);
        in_valid = rng_in[0] | rng_in[1];
        in_data  = {bytes[4*w+3], bytes[4*w+2], bytes[4*w+1], bytes[4*w]};
        acc      = in_valid && in_ready;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // command sink with back-pressure, and end-of-descriptor checks
  initial begin
    cmd_ready = 1'b0;
    forever begin
      cmd_t c;
      evt_t e;
      @(negedge clk);
      if (mon_on) begin
        rng_out   = xs(rng_out);
        cmd_ready = rng_out[2] | rng_out[5];
        if (cmd_valid && cmd_ready) begin
          if (exp_cmds.size() == 0) begin
            chk(1'b0, "R3", "unexpected command", 64'(cmd_addr), 64'd0);
          end else begin
            c = exp_cmds.pop_front();
            chk(cmd_addr == c.addr, "R3", "cmd_addr", 64'(cmd_addr), 64'(c.addr));
            chk(cmd_len == c.len, "R3", "cmd_len", 64'(cmd_len), 64'(c.len));
            chk({cmd_first, cmd_last} == {c.first, c.last}, "R4", "first/last",
                64'({cmd_first, cmd_last}), 64'({c.first, c.last}));
          end
        end
        if (desc_done) begin
          if (exp_evts.size() == 0) begin
            chk(1'b0, "R8", "unexpected desc_done", 64'd1, 64'd0);
          end else begin
            e = exp_evts.pop_front();
            chk(err_count == e.ec, "R5", "err_count", 64'(err_count), 64'(e.ec));
            chk(err_len == e.el, "R6", "err_len", 64'(err_len), 64'(e.el));
            chk(err_oversize == e.eo, "R7", "err_oversize", 64'(err_oversize), 64'(e.eo));
            chk(frame_len == e.flen, "R7", "frame_len", 64'(frame_len), 64'(e.flen));
            chk(rd_idx == e.ridx, "R8", "rd_idx", 64'(rd_idx), 64'(e.ridx));
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  task automatic fill_len(input int n, input logic [11:0] v);
    for (int k = 0; k < 20; k++) begin
      ent_addr[k] = {4'(k), 32'(32'h1000_0000 + 32'(k) * 32'h0000_0106)};
      ent_len[k]  = (k < n) ? v : 12'd0;
    end
  endtask

  initial begin
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_data     = '0;
    host_wr_idx = '0;
    repeat (5) @(negedge clk);
    chk(cmd_valid == 1'b0, "R10", "cmd_valid in reset", 64'(cmd_valid), 64'd0);
    chk(desc_done == 1'b0, "R10", "desc_done in reset", 64'(desc_done), 64'd0);
    chk(rd_idx == 8'd0, "R10", "rd_idx in reset", 64'(rd_idx), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // empty ring: words offered but never taken
    in_valid = 1'b1;
    in_data  = 32'hDEAD_BEEF;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R9", "in_ready with empty ring", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0;
    chk(rd_idx == 8'd0, "R9", "rd_idx after stall", 64'(rd_idx), 64'd0);

    // sweep every count with arithmetic addresses and lengths; wraps the ring
    for (int n = 0; n < 270; n++) begin
      for (int k = 0; k < 20; k++) begin
        ent_addr[k] = {4'((n + k) % 16),
                       32'(32'(n + 1) * 32'h0100_0193 ^ 32'(k + 1) * 32'h9E37_79B9)};
        ent_len[k]  = (k < 1 + n % 20) ? 12'(1 + ((n * 37 + k * 101) % 400)) : 12'd0;
      end
      send_desc(8'(1 + n % 20));
    end

    fill_len(20, 12'd100);
    send_desc(8'h00);                // R5 count zero
    send_desc(8'h15);                // R5 count 21
    send_desc(8'h1F);                // R5 count 31
    send_desc(8'h20);                // R2 reserved bit only, count zero
    send_desc(8'hE3);                // R2 reserved bits ignored, 3 commands
    fill_len(4, 12'd50);
    ent_len[2] = 12'd0;
    send_desc(8'h04);                // R6 zero length
    fill_len(4, 12'd50);
    ent_len[3] = 12'd4093;
    send_desc(8'h04);                // R6 just over limit
    fill_len(1, 12'd4095);
    send_desc(8'h01);                // R6 top code
    fill_len(1, 12'd4092);
    send_desc(8'h01);                // R6 limit accepted
    fill_len(3, 12'd4092);
    ent_len[2] = 12'd8;
    send_desc(8'h03);                // R7 exactly 8192
    fill_len(3, 12'd4092);
    ent_len[2] = 12'd9;
    send_desc(8'h03);                // R7 cut after two
    fill_len(20, 12'd500);
    send_desc(8'h14);                // R7 cut after sixteen

    for (int i = 0; i < 4000; i++) begin
      if (exp_cmds.size() == 0 && exp_evts.size() == 0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(exp_cmds.size() == 0, "R3", "commands outstanding", 64'(exp_cmds.size()), 64'd0);
    chk(exp_evts.size() == 0, "R8", "descriptors outstanding", 64'(exp_evts.size()), 64'd0);
    chk(rd_idx == 8'(sent), "R8", "final rd_idx", 64'(rd_idx), 64'(8'(sent)));
    chk(in_ready == 1'b0, "R9", "in_ready when caught up", 64'(in_ready), 64'd0);
    finished = 1'b1;
    report();
  end

endmodule